// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block carries out a single branch step of the ROM search on a 1-Wire bus. A host starts it and gives a preferred direction bit. The engine then uses a bit-slot layer below it to read two single-bit slots: the device ID bit first, then its complement. From that pair it chooses which branch of the search tree to take. When at least one device answered, it uses one more slot to write the chosen direction back onto the bus. It finishes with a 3-bit result code.

The engine holds one slot request at a time. It keeps that request raised until the slot layer reports either completion or timeout. The surrounding search loop can call the engine once per ROM bit and read the answer from the result code. That loop, the tracking of discrepancies and the generation of slot timing all sit outside this block.

Top module: `owire_triplet`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `done_o` and `slot_req_o` are 0 and `result_o` is 3'b000.
- R2: When `start_i` is sampled high while the engine is idle, the next cycle shows `busy_o`=1, `slot_req_o`=1 and `slot_rd_o`=1. `slot_rd_o`=1 means a read slot and 0 means a write slot. The engine also captures `pref_dir_i` on that edge.
- R3: After the ID-bit read completes, the next request is a second read slot, which returns the complement bit.
- R4: When both bits read are 1, no device is present. The step ends with `result_o`=3'b011 and issues no write slot.
- R5: When both bits read are 0, the engine writes the captured preferred direction. `result_o` is 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: When exactly one of the two bits is 1, the engine writes the ID bit value. `result_o` is 3'b101 when the ID bit is 1 and 3'b010 when it is 0.
- R7: When `slot_tmo_i` arrives during any of the three slots, the step ends at once with `result_o`=3'b011 and raises no further slot request.
- R8: A `start_i` pulse that arrives while `busy_o`=1 has no effect. The step in progress keeps its captured direction and finishes exactly once.
- R9: `done_o` is high for exactly one cycle per step, together with the new `result_o`. `result_o` changes only in a cycle where `done_o` is high. The result layout is: bit 0 is the ID bit, bit 1 is the complement bit, bit 2 is the direction taken.
- R10: A raised `slot_req_o` stays high, and `slot_rd_o` and `slot_wdata_o` stay unchanged, until `slot_done_i` or `slot_tmo_i`. A completion pulse ends exactly one slot. If the request is still high in the following cycle, that is the next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one search step (ignored while busy) |
| pref_dir_i | input | 1 | Direction to take when devices disagree |
| slot_req_o | output | 1 | Slot request to the bit-slot layer |
| slot_rd_o | output | 1 | 1 = read slot, 0 = write slot |
| slot_wdata_o | output | 1 | Bit to send in a write slot |
| slot_done_i | input | 1 | One-cycle pulse: requested slot finished |
| slot_rdata_i | input | 1 | Bit sampled in a read slot, valid with `slot_done_i` |
| slot_tmo_i | input | 1 | One-cycle pulse: requested slot timed out |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle pulse at the end of a step |
| result_o | output | 3 | {direction taken, complement bit, ID bit}, or 3'b011 |

## Verification
The assertions check the following on every cycle: that a pending slot request is held steady, that `done_o` is a single-cycle pulse, that `result_o` only moves with `done_o`, that accepting a start begins with an ID read, that a no-device pair or a timeout ends the step with 3'b011 and no further request, and that a forced branch writes the ID bit. Other behaviours can only be shown by the bench's scenarios. These are the choice between the two preferred directions, the count of write slots that actually complete, the effect of a timeout placed in each of the three slots in turn, and a start pulse that lands in the middle of a step. The bench's reference model checks these across different response latencies of the slot layer.

// File: rtl/owt_pkg.sv
package owt_pkg;

  localparam int unsigned RES_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_ID  = 2'd1,
    ST_RD_CMP = 2'd2,
    ST_WR     = 2'd3
  } owt_state_e;

  localparam logic [RES_W-1:0] RES_NONE = 3'b011;

  // no device answered: both the bit and its complement float high
  function automatic logic owt_no_dev(input logic id_b, input logic cmp_b);
    return id_b & cmp_b;
  endfunction

  // forced branch when the bits differ, otherwise the caller's choice
  function automatic logic owt_pick_dir(input logic id_b, input logic cmp_b,
                                        input logic pref);
    return (id_b ^ cmp_b) ? id_b : pref;
  endfunction

  function automatic logic [RES_W-1:0] owt_code(input logic id_b,
                                                 input logic cmp_b,
                                                 input logic dir_b);
    return {dir_b, cmp_b, id_b};
  endfunction

endpackage

// File: rtl/owt_decide.sv
module owt_decide
  import owt_pkg::*;
(
  input  logic             id_i,
  input  logic             cmp_i,
  input  logic             pref_i,
  output logic             no_dev_o,
  output logic             dir_o,
  output logic [RES_W-1:0] code_o
);

  always_comb begin
    no_dev_o = owt_no_dev(id_i, cmp_i);
    dir_o    = owt_pick_dir(id_i, cmp_i, pref_i);
    code_o   = owt_code(id_i, cmp_i, dir_o);
  end

endmodule

// File: rtl/owt_seq.sv
module owt_seq
  import owt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pref_dir_i,
  input  logic             slot_done_i,
  input  logic             slot_rdata_i,
  input  logic             slot_tmo_i,
  input  logic             no_dev_i,
  input  logic             dir_i,
  input  logic [RES_W-1:0] code_i,
  output logic             id_q_o,
  output logic             pref_q_o,
  output logic             busy_o,
  output logic             slot_req_o,
  output logic             slot_rd_o,
  output logic             slot_wdata_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  owt_state_e       st_q;
  logic             id_q, pref_q, dir_q, done_q;
  logic [RES_W-1:0] code_q, res_q;

  // named events
  logic in_slot, ev_accept, ev_tmo, ev_id_rx, ev_cmp_rx, ev_nodev, ev_branch, ev_wr_ok;

  assign in_slot   = (st_q != ST_IDLE);
  assign ev_accept = (st_q == ST_IDLE) && start_i;
  assign ev_tmo    = in_slot && slot_tmo_i;
  assign ev_id_rx  = (st_q == ST_RD_ID)  && slot_done_i && !slot_tmo_i;
  assign ev_cmp_rx = (st_q == ST_RD_CMP) && slot_done_i && !slot_tmo_i;
  assign ev_nodev  = ev_cmp_rx && no_dev_i;
  assign ev_branch = ev_cmp_rx && !no_dev_i;
  assign ev_wr_ok  = (st_q == ST_WR) && slot_done_i && !slot_tmo_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      id_q   <= 1'b0;
      pref_q <= 1'b0;
      dir_q  <= 1'b0;
      code_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_accept) begin
        pref_q <= pref_dir_i;
        st_q   <= ST_RD_ID;
      end else if (ev_tmo) begin
        res_q  <= RES_NONE;
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end else if (ev_id_rx) begin
        id_q <= slot_rdata_i;
        st_q <= ST_RD_CMP;
      end else if (ev_nodev) begin
        res_q  <= RES_NONE;
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end else if (ev_branch) begin
        dir_q  <= dir_i;
        code_q <= code_i;
        st_q   <= ST_WR;
      end else if (ev_wr_ok) begin
        res_q  <= code_q;
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end
    end
  end

  assign id_q_o       = id_q;
  assign pref_q_o     = pref_q;
  assign busy_o       = in_slot;
  assign slot_req_o   = in_slot;
  assign slot_rd_o    = in_slot && (st_q != ST_WR);
  assign slot_wdata_o = dir_q;
  assign done_o       = done_q;
  assign result_o     = res_q;

  // R2: an accepted start opens with the ID read
  p_start_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && slot_req_o && slot_rd_o));

  // R4: absent devices end the step without a write slot
  p_nodev_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nodev |=> (!slot_req_o && done_o && result_o == RES_NONE));

  // R6: differing bits force the written direction to the ID bit
  p_forced_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmp_rx && (id_q ^ slot_rdata_i)) |=> (slot_req_o && !slot_rd_o && slot_wdata_o == $past(id_q)));

  // R7: timeout closes the step with the no-device code
  p_tmo_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && slot_tmo_i) |=> (!slot_req_o && done_o && result_o == RES_NONE));

  // R9: single-cycle done, result moves only with done
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_res_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R10: a pending slot request is held unchanged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_done_i && !slot_tmo_i) |=>
      (slot_req_o && $stable(slot_rd_o) && $stable(slot_wdata_o)));

endmodule

// File: rtl/owire_triplet.sv
module owire_triplet
  import owt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pref_dir_i,
  output logic             slot_req_o,
  output logic             slot_rd_o,
  output logic             slot_wdata_o,
  input  logic             slot_done_i,
  input  logic             slot_rdata_i,
  input  logic             slot_tmo_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  logic             id_q, pref_q, no_dev, dir_w;
  logic [RES_W-1:0] code_w;

  // complement bit is taken live from the slot layer on its completion
  owt_decide u_decide (
    .id_i     (id_q),
    .cmp_i    (slot_rdata_i),
    .pref_i   (pref_q),
    .no_dev_o (no_dev),
    .dir_o    (dir_w),
    .code_o   (code_w)
  );

  owt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pref_dir_i   (pref_dir_i),
    .slot_done_i  (slot_done_i),
    .slot_rdata_i (slot_rdata_i),
    .slot_tmo_i   (slot_tmo_i),
    .no_dev_i     (no_dev),
    .dir_i        (dir_w),
    .code_i       (code_w),
    .id_q_o       (id_q),
    .pref_q_o     (pref_q),
    .busy_o       (busy_o),
    .slot_req_o   (slot_req_o),
    .slot_rd_o    (slot_rd_o),
    .slot_wdata_o (slot_wdata_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );

endmodule

// File: tb/owire_triplet_bench.sv
module owire_triplet_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, pref_dir_i = 1'b0;
  logic slot_done_i = 1'b0, slot_rdata_i = 1'b0, slot_tmo_i = 1'b0;
  logic slot_req_o, slot_rd_o, slot_wdata_o, busy_o, done_o;
  logic [2:0] result_o;

  int checks = 0, errors = 0, cyc = 0;

  // slot-layer responder state
  bit q_bits[$];
  int resp_lat = 1, resp_cnt = 0, slot_idx = 0, tmo_at = 0, wr_cnt = 0;
  bit last_wbit = 0;

  // behavioural reference
  int m_phase = 0;
  bit m_id = 0, m_cmp = 0, m_dir = 0, m_pref = 0, m_done = 0;
  int m_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owire_triplet u_owire_triplet (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .slot_req_o(slot_req_o), .slot_rd_o(slot_rd_o), .slot_wdata_o(slot_wdata_o),
    .slot_done_i(slot_done_i), .slot_rdata_i(slot_rdata_i), .slot_tmo_i(slot_tmo_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_id = 0; m_cmp = 0; m_dir = 0; m_pref = 0; m_done = 0; m_res = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (start_i) begin m_pref = pref_dir_i; m_phase = 1; end
      end else if (slot_tmo_i) begin
        m_res = 3; m_done = 1; m_phase = 0;
      end else if (slot_done_i) begin
        if (m_phase == 1) begin
          m_id = slot_rdata_i; m_phase = 2;
        end else if (m_phase == 2) begin
          m_cmp = slot_rdata_i;
          if (m_id && m_cmp) begin m_res = 3; m_done = 1; m_phase = 0; end
          else begin m_dir = (m_id != m_cmp) ? m_id : m_pref; m_phase = 3; end
        end else begin
          m_res = 4*m_dir + 2*m_cmp + m_id; m_done = 1; m_phase = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == (m_phase != 0), "R8 busy", busy_o, m_phase != 0);
      chk(slot_req_o == (m_phase != 0), "R10 req", slot_req_o, m_phase != 0);
      if (m_phase != 0) chk(slot_rd_o == (m_phase != 3), "R3 rd flag", slot_rd_o, m_phase != 3);
      if (m_phase == 3) chk(slot_wdata_o == m_dir, "R5 wdata", slot_wdata_o, m_dir);
      chk(done_o == m_done, "R9 done", done_o, m_done);
      chk(result_o == m_res[2:0], "R9 result", result_o, m_res);
    end
  end

  // slot layer model
  always @(negedge clk) begin
    if (slot_done_i || slot_tmo_i) begin
      slot_done_i = 0; slot_tmo_i = 0; resp_cnt = 0;
    end else if (slot_req_o) begin
      resp_cnt++;
      if (resp_cnt >= resp_lat) begin
        slot_idx++;
        if (slot_idx == tmo_at) slot_tmo_i = 1;
        else begin
          slot_done_i = 1;
          if (slot_rd_o) slot_rdata_i = (q_bits.size() > 0) ? q_bits.pop_front() : 1'b1;
          else begin wr_cnt++; last_wbit = slot_wdata_o; end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_step(input bit pref, input bit b_id, input bit b_cmp, input int tmo_slot,
                          input int exp_res, input int exp_wr, input bit exp_wbit,
                          input bit poke, input string tag);
    int dones;
    q_bits = {};
    q_bits.push_back(b_id);
    q_bits.push_back(b_cmp);
    tmo_at = tmo_slot; slot_idx = 0; wr_cnt = 0; dones = 0;
    @(negedge clk); start_i = 1; pref_dir_i = pref;
    @(negedge clk); start_i = 0; pref_dir_i = 0;
    chk(busy_o && slot_req_o && slot_rd_o, {tag, " R2 start opens ID read"},
        {busy_o, slot_req_o, slot_rd_o}, 7);
    for (int i = 0; i < 100; i++) begin
      if (poke && i == 0) begin start_i = 1; pref_dir_i = ~pref; end
      else if (poke && i == 1) begin start_i = 0; pref_dir_i = 0; end
      if (done_o) begin dones++; break; end
      @(negedge clk);
    end
    chk(dones == 1, {tag, " step completes"}, dones, 1);
    chk(result_o == exp_res[2:0], {tag, " result code"}, result_o, exp_res);
    chk(wr_cnt == exp_wr, {tag, " write slots"}, wr_cnt, exp_wr);
    if (exp_wr == 1) chk(last_wbit == exp_wbit, {tag, " written bit"}, last_wbit, exp_wbit);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && result_o == exp_res[2:0], {tag, " R9 idle and held"},
        {busy_o, done_o, result_o}, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !slot_req_o && result_o == 3'b000, "R1 reset state",
        {busy_o, done_o, slot_req_o, result_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !slot_req_o && result_o == 3'b000, "R1 after release",
        {busy_o, done_o, slot_req_o, result_o}, 0);
    for (int lat = 1; lat <= 3; lat += 2) begin
      resp_lat = lat;
      run_step(1, 1, 1, 0, 3'b011, 0, 0, 0, "R4 no device");
      run_step(1, 0, 0, 0, 3'b100, 1, 1, 0, "R5 disagree pref1");
      run_step(0, 0, 0, 0, 3'b000, 1, 0, 0, "R5 disagree pref0");
      run_step(0, 1, 0, 0, 3'b101, 1, 1, 0, "R6 forced one");
      run_step(1, 0, 1, 0, 3'b010, 1, 0, 0, "R6 forced zero");
      run_step(1, 0, 0, 1, 3'b011, 0, 0, 0, "R7 timeout id slot");
      run_step(1, 0, 0, 2, 3'b011, 0, 0, 0, "R7 timeout cmp slot");
      run_step(1, 1, 0, 3, 3'b011, 0, 0, 0, "R7 timeout write slot");
      run_step(1, 0, 0, 0, 3'b100, 1, 1, 1, "R8 start while busy");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule